// File: doc/BRIEF.md
# SDRAM Write Command Sequencer

This block sits between a bus master and an SDRAM device on the write path. It takes one write request at a time. Each request carries a bank, a row, a column, a single/burst flag and a sequential/non-sequential flag. The block turns the request into the device command stream: precharge, activate, write and, where needed, burst stop. It keeps one open-row entry per bank. A write that lands on an already open row goes straight to the write command. Any other write first closes and reopens the row, with the row-precharge and row-to-column delays inserted.

The device always runs fixed bursts of eight beats. A single-beat request therefore has to cut the burst short. On SDR parts the block issues a burst stop right after the first beat. On DDR parts it masks the seven unused beats and keeps the strobe enable asserted for the whole burst. The data side is described as one beat slot per controller clock, and the physical layer serializes the slots. A request that does not continue a running burst in sequence forces the open row of its bank to be closed and reopened. The device type and both delays are configuration inputs and are captured when a request is accepted. Requests are taken only while the operating mode input is zero.

Top module: `sdram_wr_sequencer`

## Requirements
- R1: After reset every bank is closed, `cmd_op` is NOP (0), `beat_en`, `dq_mask` and `dqs_en` are 0, and the first request to any bank is served with activate (2) and write, with no precharge.
- R2: A request whose bank holds an open row equal to the requested row, and which is not a burst break (R9), produces write (`cmd_op`=3) in the cycle after acceptance, with `cmd_bank` set to the bank and `cmd_addr` set to the column zero-extended. No precharge or activate is issued.
- R3: A request to a bank whose open row differs from the requested row produces precharge (1) in the cycle after acceptance, activate of the new row exactly max(`cfg_trp`,1) cycles later, and write exactly max(`cfg_trcd`,1) cycles after the activate. NOP is driven in every cycle between them.
- R4: A request to a closed bank produces activate (with `cmd_addr`=row) in the cycle after acceptance, then write exactly max(`cfg_trcd`,1) cycles later.
- R5: With `cfg_ddr`=0, a burst request drives `beat_en` for 8 consecutive cycles starting in the write cycle. `dqs_en` and `dq_mask` stay 0.
- R6: With `cfg_ddr`=1, `beat_en` and `dqs_en` are high for the 8 cycles that start one cycle after the write command.
- R7: A single request with `cfg_ddr`=0 drives `beat_en` only in the write cycle and issues burst stop (`cmd_op`=4) in the next cycle.
- R8: A single request with `cfg_ddr`=1 issues no burst stop. `dq_mask` is 0 on the first of its 8 beats and 1 on the other 7, and `dqs_en` stays high for all 8.
- R9: When the previous accepted request was a burst (`req_single`=0), a non-sequential request (`req_seq`=0) to an open bank is handled as in R3 even when its row matches. A sequential request is handled as in R2.
- R10: While `cfg_mode` is not 0, `req_ready` is 0, no command is issued and the open-row table is unchanged.
- R11: `req_ready` is 0 from acceptance until the cycle after the last data-window cycle (the last beat, or the burst stop for an SDR single). While idle with `cfg_mode`=0, `req_ready` is 1 and the outputs are quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ddr | input | 1 | Device type: 1 DDR, 0 SDR |
| cfg_mode | input | 3 | Operating mode; requests are taken only at 0 |
| cfg_trp | input | TW | Precharge-to-activate delay in cycles |
| cfg_trcd | input | TW | Activate-to-write delay in cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_single | input | 1 | 1 single write, 0 burst write |
| req_seq | input | 1 | 1 sequential transfer, 0 non-sequential |
| cmd_op | output | 3 | Command: 0 NOP, 1 precharge, 2 activate, 3 write, 4 burst stop |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_addr | output | ROW_W | Row for activate, column for write |
| beat_en | output | 1 | A data beat slot is active |
| dq_mask | output | 1 | Mask the current beat |
| dqs_en | output | 1 | Data strobe toggles in this slot |

## Verification
The case that is hardest to reach is the forced close of a row that already matches. The master has to issue a burst followed by a non-sequential request to the same bank and row. Otherwise the page-hit path hides the rule. The stimulus walks one bank through closed, activated, sequential hit, forced break and plain miss. It repeats this under both device types and several delay settings. Afterwards it holds a request in a non-zero mode and then shows that a later hit still goes straight to write.

// File: rtl/sdram_wr_sequencer.sv
module sdram_wr_sequencer #(
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int BANKS = 4,
  parameter int TW    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_ddr,
  input  logic [2:0]               cfg_mode,
  input  logic [TW-1:0]            cfg_trp,
  input  logic [TW-1:0]            cfg_trcd,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [$clog2(BANKS)-1:0] req_bank,
  input  logic [ROW_W-1:0]         req_row,
  input  logic [COL_W-1:0]         req_col,
  input  logic                     req_single,
  input  logic                     req_seq,
  output logic [2:0]               cmd_op,
  output logic [$clog2(BANKS)-1:0] cmd_bank,
  output logic [ROW_W-1:0]         cmd_addr,
  output logic                     beat_en,
  output logic                     dq_mask,
  output logic                     dqs_en
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int BL     = 8;
  localparam int PH_W   = $clog2(BL + 1);
  localparam int GW     = TW + 1;
  localparam logic [2:0] OP_NOP = 3'd0, OP_PRE = 3'd1, OP_ACT = 3'd2, OP_WR = 3'd3, OP_BST = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_ACT, S_DATA} st_t;

  st_t                st;
  logic [TW-1:0]      wcnt, r_trp, r_trcd;
  logic [PH_W-1:0]    ph;
  logic [ROW_W-1:0]   r_row;
  logic [COL_W-1:0]   r_col;
  logic               r_single, r_ddr, prev_burst;
  logic [BANKS-1:0]   row_ok;
  logic [ROW_W-1:0]   row_tab [BANKS];

  wire take      = req_valid && req_ready;
  wire bank_open = row_ok[req_bank];
  wire row_match = row_tab[req_bank] == req_row;
  wire brk       = prev_burst && !req_seq;
  wire in_data   = st == S_DATA;
  wire [PH_W-1:0] ph_last = r_ddr ? PH_W'(BL) : (r_single ? PH_W'(1) : PH_W'(BL - 1));
  wire [ROW_W-1:0] col_ext = {{(ROW_W - COL_W){1'b0}}, r_col};
  wire [ROW_W-1:0] req_col_ext = {{(ROW_W - COL_W){1'b0}}, req_col};

  assign req_ready = (st == S_IDLE) && (cfg_mode == 3'd0);
  assign beat_en   = in_data && (r_ddr ? (ph != '0) : (r_single ? (ph == '0) : 1'b1));
  assign dqs_en    = in_data && r_ddr && (ph != '0);
  assign dq_mask   = in_data && r_ddr && r_single && (ph >= PH_W'(2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      wcnt       <= '0;
      r_trp      <= '0;
      r_trcd     <= '0;
      ph         <= '0;
      r_row      <= '0;
      r_col      <= '0;
      r_single   <= 1'b0;
      r_ddr      <= 1'b0;
      prev_burst <= 1'b0;
      row_ok     <= '0;
      cmd_op     <= OP_NOP;
      cmd_bank   <= '0;
      cmd_addr   <= '0;
      for (int i = 0; i < BANKS; i++) row_tab[i] <= '0;
    end else begin
      cmd_op <= OP_NOP;
      case (st)
        S_IDLE: if (take) begin
          r_row      <= req_row;
          r_col      <= req_col;
          r_single   <= req_single;
          r_ddr      <= cfg_ddr;
          r_trp      <= cfg_trp;
          r_trcd     <= cfg_trcd;
          prev_burst <= !req_single;
          cmd_bank   <= req_bank;
          if (bank_open && row_match && !brk) begin
            cmd_op   <= OP_WR;
            cmd_addr <= req_col_ext;
            ph       <= '0;
            st       <= S_DATA;
          end else if (bank_open) begin
            cmd_op           <= OP_PRE;
            row_ok[req_bank] <= 1'b0;
            wcnt             <= cfg_trp;
            st               <= S_PRE;
          end else begin
            cmd_op            <= OP_ACT;
            cmd_addr          <= req_row;
            row_ok[req_bank]  <= 1'b1;
            row_tab[req_bank] <= req_row;
            wcnt              <= cfg_trcd;
            st                <= S_ACT;
          end
        end
        S_PRE: if (wcnt <= TW'(1)) begin
          cmd_op            <= OP_ACT;
          cmd_addr          <= r_row;
          row_ok[cmd_bank]  <= 1'b1;
          row_tab[cmd_bank] <= r_row;
          wcnt              <= r_trcd;
          st                <= S_ACT;
        end else wcnt <= wcnt - TW'(1);
        S_ACT: if (wcnt <= TW'(1)) begin
          cmd_op   <= OP_WR;
          cmd_addr <= col_ext;
          ph       <= '0;
          st       <= S_DATA;
        end else wcnt <= wcnt - TW'(1);
        S_DATA: begin
          if (!r_ddr && r_single && ph == '0) cmd_op <= OP_BST;
          if (ph == ph_last) st <= S_IDLE;
          else ph <= ph + PH_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [2:0]    last_op;
  logic [GW-1:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_op <= OP_NOP;
      gap     <= '0;
    end else if (cmd_op != OP_NOP) begin
      last_op <= cmd_op;
      gap     <= GW'(1);
    end else if (gap != '1) gap <= gap + GW'(1);
  end

  assert_trp_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_ACT && last_op == OP_PRE) |-> gap >= {1'b0, r_trp});
  assert_trcd_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_WR && last_op == OP_ACT) |-> gap >= {1'b0, r_trcd});
  assert_write_open_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_WR) |-> (row_ok[cmd_bank] && row_tab[cmd_bank] == r_row));
  assert_bst_sdr_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_BST) |-> (!r_ddr && r_single && $past(cmd_op) == OP_WR));
  assert_mask_with_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dq_mask |-> dqs_en);
  assert_sdr_beat_at_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(beat_en) && !r_ddr) |-> cmd_op == OP_WR);
  assert_ddr_strobe_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dqs_en) |-> $past(cmd_op) == OP_WR);
endmodule

// File: tb/sim_sdram_wr_sequencer.sv
module sim_sdram_wr_sequencer;
  localparam int ROW_W = 13, COL_W = 10, BANKS = 4, TW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_ddr = 1'b0;
  logic [2:0] cfg_mode = 3'd0;
  logic [TW-1:0] cfg_trp = 4'd2, cfg_trcd = 4'd3;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_single = 1'b0, req_seq = 1'b0;
  logic [2:0] cmd_op;
  logic [1:0] cmd_bank;
  logic [ROW_W-1:0] cmd_addr;
  logic beat_en, dq_mask, dqs_en;

  always #2 clk = ~clk;

  sdram_wr_sequencer #(.ROW_W(ROW_W), .COL_W(COL_W), .BANKS(BANKS), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_ddr(cfg_ddr), .cfg_mode(cfg_mode),
    .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_single(req_single),
    .req_seq(req_seq), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .beat_en(beat_en), .dq_mask(dq_mask), .dqs_en(dqs_en));

  typedef struct packed {
    logic [2:0] op; logic [1:0] bank; logic [ROW_W-1:0] addr; logic beat, mask, dqs;
  } exp_t;

  exp_t  eq[$];
  string tq[$];
  exp_t  e;
  string t;
  string idle_tag = "R11";
  int errs = 0, checks = 0, cyc = 0;
  bit mon_on = 1'b0;
  bit rv[4];
  logic [ROW_W-1:0] rr[4];
  bit prev_b = 1'b0;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errs++; checks++;
      $display("FAIL watchdog: run hung, got cycle %0d expected under 20000", cyc);
      finish_run();
    end
  end

  always @(negedge clk) if (mon_on) begin
    checks++;
    if (eq.size() > 0) begin
      e = eq.pop_front();
      t = tq.pop_front();
      if (cmd_op !== e.op || beat_en !== e.beat || dq_mask !== e.mask || dqs_en !== e.dqs ||
          req_ready !== 1'b0 ||
          (e.op != 3'd0 && cmd_bank !== e.bank) ||
          ((e.op == 3'd2 || e.op == 3'd3) && cmd_addr !== e.addr)) begin
        errs++;
        $display("FAIL %s: got op=%0d bank=%0d addr=%0h beat=%b mask=%b dqs=%b rdy=%b expected op=%0d bank=%0d addr=%0h beat=%b mask=%b dqs=%b rdy=0",
                 t, cmd_op, cmd_bank, cmd_addr, beat_en, dq_mask, dqs_en, req_ready,
                 e.op, e.bank, e.addr, e.beat, e.mask, e.dqs);
      end
    end else if (cmd_op !== 3'd0 || beat_en !== 1'b0 || dq_mask !== 1'b0 || dqs_en !== 1'b0 ||
                 req_ready !== (cfg_mode == 3'd0)) begin
      errs++;
      $display("FAIL %s idle: got op=%0d beat=%b mask=%b dqs=%b rdy=%b expected op=0 beat=0 mask=0 dqs=0 rdy=%b",
               idle_tag, cmd_op, beat_en, dq_mask, dqs_en, req_ready, cfg_mode == 3'd0);
    end
  end

  task automatic push(input logic [2:0] op, input logic [1:0] b, input logic [ROW_W-1:0] a,
                      input logic bt, input logic mk, input logic dq, input string tg);
    exp_t x;
    x.op = op; x.bank = b; x.addr = a; x.beat = bt; x.mask = mk; x.dqs = dq;
    eq.push_back(x);
    tq.push_back(tg);
  endtask

  task automatic do_req(input logic [1:0] b, input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col,
                        input bit single, input bit seq, input string tg);
    int tp, tc, last;
    bit force_close, ddr;
    while (eq.size() != 0) @(negedge clk);
    @(negedge clk); #1;
    req_bank = b; req_row = row; req_col = col; req_single = single; req_seq = seq; req_valid = 1'b1;
    @(posedge clk);
    tp = (cfg_trp == 0) ? 1 : int'(cfg_trp);
    tc = (cfg_trcd == 0) ? 1 : int'(cfg_trcd);
    ddr = cfg_ddr;
    force_close = prev_b && !seq;
    if (rv[b] && rr[b] == row && !force_close) begin
      // R2 direct write on open row
    end else if (rv[b]) begin
      // R3 / R9 precharge, activate, write
      push(3'd1, b, '0, 0, 0, 0, tg);
      for (int i = 1; i < tp; i++) push(3'd0, b, '0, 0, 0, 0, tg);
      push(3'd2, b, row, 0, 0, 0, tg);
      for (int i = 1; i < tc; i++) push(3'd0, b, '0, 0, 0, 0, tg);
    end else begin
      // R4 closed bank
      push(3'd2, b, row, 0, 0, 0, tg);
      for (int i = 1; i < tc; i++) push(3'd0, b, '0, 0, 0, 0, tg);
    end
    last = ddr ? 8 : (single ? 1 : 7);
    for (int p = 0; p <= last; p++) begin
      logic [2:0] op;
      logic bt, mk, dq;
      op = (p == 0) ? 3'd3 : ((!ddr && single && p == 1) ? 3'd4 : 3'd0);
      if (ddr) begin
        bt = (p >= 1); dq = (p >= 1); mk = single && (p >= 2);   // R6 R8
      end else begin
        bt = single ? (p == 0) : 1'b1; dq = 1'b0; mk = 1'b0;      // R5 R7
      end
      push(op, b, {{(ROW_W-COL_W){1'b0}}, col}, bt, mk, dq, tg);
    end
    rv[b] = 1'b1; rr[b] = row; prev_b = !single;
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin rv[i] = 1'b0; rr[i] = '0; end
    repeat (3) @(negedge clk);
    checks++;
    if (cmd_op !== 3'd0 || beat_en !== 1'b0 || dq_mask !== 1'b0 || dqs_en !== 1'b0) begin
      errs++;
      $display("FAIL R1 reset: got op=%0d beat=%b mask=%b dqs=%b expected all 0", cmd_op, beat_en, dq_mask, dqs_en);
    end
    #1 rst_n = 1'b1;
    mon_on = 1'b1;

    // SDR, trp=2 trcd=3
    do_req(2'd0, 13'd5, 10'd8,  0, 0, "R1 R4 R5 first burst to closed bank");
    do_req(2'd0, 13'd5, 10'd16, 0, 1, "R2 R9 sequential hit");
    do_req(2'd0, 13'd5, 10'd24, 0, 0, "R9 non-sequential break on same row");
    do_req(2'd0, 13'd7, 10'd3,  1, 0, "R3 R7 row miss single SDR");
    do_req(2'd0, 13'd7, 10'd4,  1, 0, "R2 R7 hit single SDR");
    do_req(2'd1, 13'd3, 10'd9,  1, 0, "R4 R7 second bank closed");
    do_req(2'd0, 13'd7, 10'd5,  1, 0, "R2 per-bank row kept");

    // DDR, trp=1 trcd=1
    while (eq.size() != 0) @(negedge clk);
    @(negedge clk); #1;
    cfg_ddr = 1'b1; cfg_trp = 4'd1; cfg_trcd = 4'd1;
    do_req(2'd1, 13'd3, 10'd1,  0, 0, "R2 R6 DDR burst hit");
    do_req(2'd1, 13'd4, 10'd2,  1, 0, "R3 R8 R9 DDR single after burst");
    do_req(2'd2, 13'd9, 10'd7,  1, 0, "R4 R8 DDR single closed bank");

    // DDR, trp=4 trcd=2
    while (eq.size() != 0) @(negedge clk);
    @(negedge clk); #1;
    cfg_trp = 4'd4; cfg_trcd = 4'd2;
    do_req(2'd2, 13'd10, 10'd11, 0, 0, "R3 R6 long delays");

    // R10: non-zero mode blocks requests
    while (eq.size() != 0) @(negedge clk);
    @(negedge clk); #1;
    idle_tag = "R10";
    cfg_mode = 3'd3;
    req_bank = 2'd2; req_row = 13'd99; req_col = 10'd1; req_single = 1'b0; req_seq = 1'b0;
    req_valid = 1'b1;
    repeat (6) @(negedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk); #1 cfg_mode = 3'd0;
    @(negedge clk);
    idle_tag = "R11";
    do_req(2'd2, 13'd10, 10'd12, 1, 1, "R10 R9 table unchanged, sequential hit after burst");

    while (eq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule